// File: doc/BRIEF.md
# Scan Test Sequencer

This block runs one scan chain through a full manufacturing test. Once started, it first exercises the chain itself. It shifts a repeating two-zeros, two-ones pattern through the chain so that every flop sees all four bit transitions, and it marks the cycles in which the pattern emerges at the chain output.

After that it applies a parameterised number of combinational vectors. For each vector it shifts a state into the chain, then spends one cycle in normal mode with the vector's primary-input value presented, so the chain captures the logic response. The response then shifts out while the next state shifts in. A final shift empties the chain of the last response.

The controller drives the test-control level, a chain-advance enable, the serial bit for the chain input, and strobes that tell an external comparator when the chain output carries a meaningful bit. Vectors arrive one at a time through a valid/take handshake. A vector that is late freezes the whole sequence without losing a cycle of the count.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is high and in the cycle after reset, chainEn, vecTake, respValid, flushChk and done are 0, and testCtl is 1 (normal mode).
- R2: After start, the first CHAIN_LEN+4 enabled cycles have testCtl=0. In the flush cycle numbered i (from 0), scanIn is bit 1 of i, which gives the sequence 0,0,1,1,... flushChk is 1 exactly when i is at least CHAIN_LEN. In those cycles flushBit equals bit 1 of (i-CHAIN_LEN), and that is the value then present at the chain output.
- R3: Each vector is taken in the first shift cycle of its window. vecTake is 1 only when vecValid is 1. In that cycle scanIn is vecState[CHAIN_LEN-1], and the following cycles send the lower bits, most significant bit first. After CHAIN_LEN shifts the chain holds vecState.
- R4: Each shift window of a vector is followed by exactly one enabled cycle with testCtl=1. In that cycle piValid is 1 and piOut equals the vecPi taken with that vector.
- R5: respValid is 1 on exactly the shift cycles that follow a capture. In those cycles the chain output carries the captured response, most significant bit first. respValid is 0 during the flush and during the first vector's shift-in.
- R6: In the final CHAIN_LEN shift cycles after the last capture, scanIn is 0.
- R7: done rises after exactly (NUM_VEC+2)*CHAIN_LEN+NUM_VEC+4 enabled cycles. It stays 1 with chainEn at 0 until start or reset.
- R8: When a vector is due and vecValid is 0, chainEn is 0 and the sequence does not advance. The total number of enabled cycles is unchanged by such stalls.
- R9: A synchronous reset in the middle of a test returns the block to the idle outputs of R1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a test from idle or from done |
| vecValid | input | 1 | Vector supply has a vector ready |
| vecState | input | CHAIN_LEN | State to load into the chain, MSB shifted first |
| vecPi | input | PI_W | Primary-input value for this vector's capture |
| vecTake | output | 1 | Vector accepted this cycle |
| testCtl | output | 1 | 0 = shift mode, 1 = normal (capture) mode |
| chainEn | output | 1 | Chain clock enable; the chain moves only when 1 |
| scanIn | output | 1 | Serial bit for the chain input |
| piOut | output | PI_W | Primary inputs to apply during capture |
| piValid | output | 1 | Capture cycle marker for piOut |
| respValid | output | 1 | Chain output carries a response bit this cycle |
| flushChk | output | 1 | Chain output carries a flush pattern bit this cycle |
| flushBit | output | 1 | Expected chain output during flushChk |
| done | output | 1 | Test complete |

## Verification
The bench builds the block with an 8-flop chain, 3 vectors and 4 primary inputs. With those values the whole test is 47 cycles long, and the flush window, both overlapped shift windows and the unload window can all be checked bit by bit. A model of the chain and a small combinational function in the bench turns every vector into an expected response stream. One pass supplies vectors at once, and a second pass withholds them on a pseudo-random pattern, so the stall path and the unchanged cycle total are both reached. A reset during the flush covers the return to idle.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_FLUSH = 2'd1,
    SRC_VEC   = 2'd2
  } srcSel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_SHIFT = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadVec;
    logic    shiftVec;
    logic    capt;
    srcSel_e src;
    logic    patBit;
  } dpCtl_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int NUM_VEC   = 16,
  parameter int PH_W      = $clog2(CHAIN_LEN + 4),
  parameter int VI_W      = $clog2(NUM_VEC + 1),
  parameter int CY_W      = $clog2((NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 5)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            vecValid,
  output logic            vecTake,
  output logic            testCtl,
  output logic            chainEn,
  output logic            respValid,
  output logic            flushChk,
  output logic            flushBit,
  output logic            done,
  output logic [CY_W-1:0] cycleCnt,
  output dpCtl_t          dpCtl
);

  localparam logic [PH_W-1:0] FLUSH_LAST = PH_W'(CHAIN_LEN + 3);
  localparam logic [PH_W-1:0] SHIFT_LAST = PH_W'(CHAIN_LEN - 1);
  localparam logic [PH_W-1:0] CHAIN_P    = PH_W'(CHAIN_LEN);
  localparam logic [VI_W-1:0] VEC_LAST   = VI_W'(NUM_VEC);

  seqState_e       state, stateNxt;
  logic [PH_W-1:0] phaseCnt;
  logic [VI_W-1:0] vecIdx;
  logic            unloadPh;
  logic            haveResp;
  logic            needVec;
  logic            stall;
  logic            running;
  logic [PH_W-1:0] flushOff;

  assign running  = (state == ST_FLUSH) || (state == ST_SHIFT) || (state == ST_CAPT);
  assign needVec  = (state == ST_SHIFT) && (phaseCnt == '0) && !unloadPh;
  assign stall    = needVec && !vecValid;
  assign chainEn  = running && !stall;
  assign testCtl  = !((state == ST_FLUSH) || (state == ST_SHIFT));
  assign vecTake  = needVec && vecValid;
  assign respValid = (state == ST_SHIFT) && haveResp && !stall;
  assign flushOff = phaseCnt - CHAIN_P;
  assign flushChk = (state == ST_FLUSH) && (phaseCnt >= CHAIN_P);
  assign flushBit = flushChk && flushOff[1];
  assign done     = (state == ST_DONE);

  always_comb begin
    dpCtl          = '0;
    dpCtl.src      = SRC_ZERO;
    dpCtl.loadVec  = vecTake;
    dpCtl.shiftVec = (state == ST_SHIFT) && !stall && !vecTake;
    dpCtl.capt     = (state == ST_CAPT);
    dpCtl.patBit   = phaseCnt[1];
    if (state == ST_FLUSH)
      dpCtl.src = SRC_FLUSH;
    else if ((state == ST_SHIFT) && !unloadPh)
      dpCtl.src = SRC_VEC;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE,
      ST_DONE:  if (start) stateNxt = ST_FLUSH;
      ST_FLUSH: if (phaseCnt == FLUSH_LAST) stateNxt = ST_SHIFT;
      ST_SHIFT: if (!stall && (phaseCnt == SHIFT_LAST))
                  stateNxt = unloadPh ? ST_DONE : ST_CAPT;
      ST_CAPT:  stateNxt = ST_SHIFT;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      vecIdx   <= '0;
      unloadPh <= 1'b0;
      haveResp <= 1'b0;
      cycleCnt <= '0;
    end else begin
      state <= stateNxt;
      if ((state == ST_IDLE) || (state == ST_DONE)) begin
        if (start) begin
          phaseCnt <= '0;
          vecIdx   <= '0;
          unloadPh <= 1'b0;
          haveResp <= 1'b0;
          cycleCnt <= '0;
        end
      end else if (chainEn) begin
        cycleCnt <= cycleCnt + 1'b1;
        if (vecTake) vecIdx <= vecIdx + 1'b1;
        case (state)
          ST_FLUSH: begin
            if (phaseCnt == FLUSH_LAST) begin
              phaseCnt <= '0;
              unloadPh <= (NUM_VEC == 0);
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
          ST_SHIFT: begin
            if (phaseCnt == SHIFT_LAST) phaseCnt <= '0;
            else                        phaseCnt <= phaseCnt + 1'b1;
          end
          ST_CAPT: begin
            phaseCnt <= '0;
            haveResp <= 1'b1;
            unloadPh <= (vecIdx == VEC_LAST);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int PI_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpCtl_t               dpCtl,
  input  logic [CHAIN_LEN-1:0] vecState,
  input  logic [PI_W-1:0]      vecPi,
  output logic                 scanIn,
  output logic [PI_W-1:0]      piOut,
  output logic                 piValid
);

  logic [CHAIN_LEN-1:0] stateReg;
  logic [PI_W-1:0]      piReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= '0;
      piReg    <= '0;
    end else if (dpCtl.loadVec) begin
      stateReg <= {vecState[CHAIN_LEN-2:0], 1'b0};
      piReg    <= vecPi;
    end else if (dpCtl.shiftVec) begin
      stateReg <= {stateReg[CHAIN_LEN-2:0], 1'b0};
    end
  end

  always_comb begin
    case (dpCtl.src)
      SRC_FLUSH: scanIn = dpCtl.patBit;
      SRC_VEC:   scanIn = dpCtl.loadVec ? vecState[CHAIN_LEN-1] : stateReg[CHAIN_LEN-1];
      default:   scanIn = 1'b0;
    endcase
  end

  assign piOut   = piReg;
  assign piValid = dpCtl.capt;

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 32,
  parameter int NUM_VEC   = 16,
  parameter int PI_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 vecValid,
  input  logic [CHAIN_LEN-1:0] vecState,
  input  logic [PI_W-1:0]      vecPi,
  output logic                 vecTake,
  output logic                 testCtl,
  output logic                 chainEn,
  output logic                 scanIn,
  output logic [PI_W-1:0]      piOut,
  output logic                 piValid,
  output logic                 respValid,
  output logic                 flushChk,
  output logic                 flushBit,
  output logic                 done
);

  localparam int TOTAL = (NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 4;
  localparam int CY_W  = $clog2(TOTAL + 1);

  dpCtl_t          dpCtl;
  logic [CY_W-1:0] cycleCnt;

  scan_seq_ctrl #(
    .CHAIN_LEN(CHAIN_LEN),
    .NUM_VEC  (NUM_VEC),
    .CY_W     (CY_W)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .vecValid (vecValid),
    .vecTake  (vecTake),
    .testCtl  (testCtl),
    .chainEn  (chainEn),
    .respValid(respValid),
    .flushChk (flushChk),
    .flushBit (flushBit),
    .done     (done),
    .cycleCnt (cycleCnt),
    .dpCtl    (dpCtl)
  );

  scan_seq_dp #(
    .CHAIN_LEN(CHAIN_LEN),
    .PI_W     (PI_W)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .dpCtl   (dpCtl),
    .vecState(vecState),
    .vecPi   (vecPi),
    .scanIn  (scanIn),
    .piOut   (piOut),
    .piValid (piValid)
  );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int TOTAL = 100,
  parameter int CY_W  = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            vecValid,
  input logic            vecTake,
  input logic            testCtl,
  input logic            chainEn,
  input logic            respValid,
  input logic            flushChk,
  input logic            piValid,
  input logic            done,
  input logic [CY_W-1:0] cycleCnt
);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chainEn && testCtl && !done && !respValid && !flushChk));

  assert_flush_in_shift_R2: assert property (@(posedge clk) disable iff (rst)
    flushChk |-> (chainEn && !testCtl && !respValid));

  assert_take_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    vecTake |-> (vecValid && chainEn && !testCtl));

  assert_capture_single_R4: assert property (@(posedge clk) disable iff (rst)
    (chainEn && testCtl) |=> !testCtl);

  assert_capture_pi_R4: assert property (@(posedge clk) disable iff (rst)
    piValid |-> (chainEn && testCtl));

  assert_resp_in_shift_R5: assert property (@(posedge clk) disable iff (rst)
    respValid |-> (chainEn && !testCtl));

  assert_done_count_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cycleCnt == CY_W'(TOTAL)));

  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (!testCtl && !chainEn) |-> !vecValid);

endmodule

bind scan_test_seq scan_seq_chk #(
  .TOTAL((NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 4),
  .CY_W ($clog2((NUM_VEC + 2) * CHAIN_LEN + NUM_VEC + 5))
) uChk (
  .clk      (clk),
  .rst      (rst),
  .vecValid (vecValid),
  .vecTake  (vecTake),
  .testCtl  (testCtl),
  .chainEn  (chainEn),
  .respValid(respValid),
  .flushChk (flushChk),
  .piValid  (piValid),
  .done     (done),
  .cycleCnt (cycleCnt)
);

// File: tb/tb_scan_test_seq.sv
`timescale 1ns/100ps
module tb_scan_test_seq;

  localparam int L     = 8;
  localparam int V     = 3;
  localparam int P     = 4;
  localparam int FL    = L + 4;
  localparam int TOTAL = (V + 2) * L + V + 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         vecValid = 1'b0;
  logic [L-1:0] vecState = '0;
  logic [P-1:0] vecPi = '0;
  logic         vecTake, testCtl, chainEn, scanIn, piValid, respValid;
  logic         flushChk, flushBit, done;
  logic [P-1:0] piOut;

  scan_test_seq #(.CHAIN_LEN(L), .NUM_VEC(V), .PI_W(P)) dut (
    .clk(clk), .rst(rst), .start(start), .vecValid(vecValid),
    .vecState(vecState), .vecPi(vecPi), .vecTake(vecTake),
    .testCtl(testCtl), .chainEn(chainEn), .scanIn(scanIn),
    .piOut(piOut), .piValid(piValid), .respValid(respValid),
    .flushChk(flushChk), .flushBit(flushBit), .done(done)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // scoreboard queues
  logic         respQ[$];
  logic [P-1:0] piQ[$];
  logic [L-1:0] vecArr[V];
  logic [P-1:0] piArr[V];

  // bench model of the chain under test
  logic [L-1:0] bChain = '0;
  int  activeCnt, captCnt, takeCnt, wallCnt;
  bit  lastCapt, tookFlag, monOn;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [L-1:0] combFn(input logic [L-1:0] s, input logic [P-1:0] p);
    return {s[L-2:0], s[L-1]} ^ {p, ~p};
  endfunction

  task automatic pushVec(input int k);
    logic [L-1:0] resp;
    vecArr[k] = L'(8'hA5 ^ (k * 37));
    piArr[k]  = P'(k + 3);
    piQ.push_back(piArr[k]);
    resp = combFn(vecArr[k], piArr[k]);
    for (int b = L - 1; b >= 0; b--) respQ.push_back(resp[b]);
  endtask

  // monitor: samples just before each rising edge
  always begin
    @(negedge clk);
    #2;
    if (monOn && !rst) begin
      bit due;
      wallCnt++;
      due = (takeCnt < V) && (activeCnt == FL || lastCapt) && !testCtl;
      if (due) begin
        if (vecValid) chk(vecTake == 1'b1 && chainEn, "R3 take when due", vecTake, 1);
        else          chk(chainEn == 1'b0, "R8 stall holds chain", chainEn, 0);
      end
      if (vecTake) begin
        chk(vecValid == 1'b1, "R3 take needs valid", vecValid, 1);
        tookFlag = 1'b1;
        takeCnt++;
      end
      if (chainEn) begin
        if (!testCtl) begin
          if (activeCnt < FL) begin
            chk(scanIn == 1'((activeCnt >> 1) & 1), "R2 flush pattern", scanIn, (activeCnt >> 1) & 1);
            if (activeCnt >= L) begin
              chk(flushChk && bChain[L-1] == 1'(((activeCnt - L) >> 1) & 1), "R2 flush out",
                  bChain[L-1], ((activeCnt - L) >> 1) & 1);
              chk(flushBit == bChain[L-1], "R2 flushBit", flushBit, bChain[L-1]);
            end else begin
              chk(flushChk == 1'b0, "R2 flushChk early", flushChk, 0);
            end
            chk(respValid == 1'b0, "R5 no resp in flush", respValid, 0);
          end else begin
            chk(respValid == (captCnt > 0), "R5 respValid timing", respValid, captCnt > 0);
            if (captCnt == V) chk(scanIn == 1'b0, "R6 unload fill", scanIn, 0);
          end
          if (respValid) begin
            if (respQ.size() == 0) chk(1'b0, "R5 unexpected response", 1, 0);
            else begin
              logic e;
              e = respQ.pop_front();
              chk(bChain[L-1] == e, "R5 response bit", bChain[L-1], e);
            end
          end
          bChain = {bChain[L-2:0], scanIn};
          lastCapt = 1'b0;
        end else begin
          logic [P-1:0] ep;
          ep = (piQ.size() > 0) ? piQ.pop_front() : '0;
          chk(piValid && piOut == ep, "R4 capture pi", piOut, ep);
          bChain = combFn(bChain, ep);
          captCnt++;
          lastCapt = 1'b1;
        end
        activeCnt++;
      end
    end
  end

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", wdog);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int lfsr = 32'h1D;

  task automatic runTest(input bit withStalls);
    int idx;
    respQ.delete(); piQ.delete();
    activeCnt = 0; captCnt = 0; takeCnt = 0; wallCnt = 0;
    lastCapt = 0; tookFlag = 0;
    for (int k = 0; k < V; k++) pushVec(k);
    @(negedge clk);
    monOn = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (!done) begin
      if (tookFlag) begin idx++; tookFlag = 0; end
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4 : 0);
      vecValid = (idx < V) && !(withStalls && (lfsr & 3) != 0);
      if (idx < V) begin vecState = vecArr[idx]; vecPi = piArr[idx]; end
      @(negedge clk);
    end
    vecValid = 1'b0;
    chk(activeCnt == TOTAL, "R7 enabled cycle total", activeCnt, TOTAL);
    chk(captCnt == V, "R4 capture count", captCnt, V);
    chk(respQ.size() == 0, "R5 all responses seen", respQ.size(), 0);
    if (withStalls) chk(wallCnt > TOTAL, "R8 stalls occurred", wallCnt, TOTAL + 1);
    monOn = 1'b0;
    @(negedge clk); #2;
    chk(done && !chainEn, "R7 done holds", done, 1);
  endtask

  initial begin
    monOn = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!chainEn && testCtl && !done && !respValid && !vecTake && !flushChk, "R1 reset state", chainEn, 0);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!chainEn && testCtl && !done, "R1 idle after reset", chainEn, 0);

    // reset in the middle of the flush
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    #2;
    chk(chainEn && !testCtl, "R9 running before reset", chainEn, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #2;
    chk(!chainEn && testCtl && !done && !flushChk, "R9 idle after mid reset", chainEn, 0);

    runTest(1'b0);
    runTest(1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule